// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a 10-bit successive-approximation converter. In conversion mode it runs a binary search over the converter code. Each step it presents a trial code to an external DAC and comparator pair and reads back a one-bit verdict. When the last bit is decided, the code is stored in a 16-bit result word as a signed two's complement number centred on mid-scale. The word can be right-aligned with sign extension, or left-aligned with zero padding so that the upper byte alone reads as an 8-bit signed value.

A conversion is launched either by a software start pulse or by a timer trigger pulse; a select input picks which source is honoured. Every search step lasts a programmable number of clock cycles, which lets the total conversion time match the analog settling needs. A done flag, mirrored on an interrupt line, marks each finished conversion. Software clears it explicitly, or it clears as a side effect of reading the high result byte. In output mode the search is bypassed, and a written 10-bit value is driven straight onto the converter code lines.

Top module: `sar_conv_ctrl`

## Requirements
- R1: When idle in conversion mode (`cfg_dac_mode`=0), the chosen trigger (`sw_start` if `cfg_trig_sel`=0, `tmr_trig` if `cfg_trig_sel`=1) starts a conversion. On the next cycle `busy` is 1 and `trial_code` is 10'h200.
- R2: Each search step lasts `cfg_div`+1 cycles. At the end of a step, bit k of `trial_code` (k running 9 down to 0) is kept when `cmp_in`=1 and cleared when `cmp_in`=0. Then bit k-1 is set.
- R3: After ten steps, `busy` returns to 0, `done` becomes 1 and `result` is loaded, all on the same clock edge. `trial_code` then holds the final search code.
- R4: The signed result is the final search code with bit 9 inverted (mid-scale 10'h200 maps to 0).
- R5: With `cfg_left_adj`=0, `result[9:0]` holds the signed code and `result[15:10]` are copies of its bit 9.
- R6: With `cfg_left_adj`=1, `result[15:6]` holds the signed code and `result[5:0]` are 0. `result[15:8]` is then the 8-bit signed value.
- R7: The trigger input that is not selected has no effect. A trigger that arrives while `busy`=1 has no effect.
- R8: A `done_clr` or `rd_hi` pulse clears `done` on the next cycle. If a conversion ends in the same cycle, the set wins and `done` is 1.
- R9: `irq` is 1 exactly when `done` is 1.
- R10: In output mode (`cfg_dac_mode`=1), `dac_wr_en` loads `dac_wr_data` into `trial_code` on the next cycle, and triggers start no conversion.
- R11: `result` changes only on the edge that ends a conversion. A change of `cfg_left_adj` at any other time leaves it unchanged.
- R12: While `rst` is 1, `busy`, `done`, `irq`, `trial_code` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dac_mode | input | 1 | 1 = output (DAC) mode, 0 = conversion mode |
| cfg_left_adj | input | 1 | 1 = left-aligned result, 0 = right-aligned |
| cfg_trig_sel | input | 1 | 0 = software start, 1 = timer trigger |
| cfg_div | input | 8 | Cycles per search step minus one |
| sw_start | input | 1 | Software start pulse |
| tmr_trig | input | 1 | Timer trigger pulse |
| dac_wr_en | input | 1 | Output-mode code write strobe |
| dac_wr_data | input | 10 | Output-mode code value |
| cmp_in | input | 1 | Comparator verdict: 1 = input at or above trial level |
| done_clr | input | 1 | Clear pulse for the done flag |
| rd_hi | input | 1 | High result byte read strobe (clears done) |
| trial_code | output | 10 | Code driven to the converter |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion complete flag |
| irq | output | 1 | Interrupt request |
| result | output | 16 | Formatted signed result word |

## Verification
The end of a conversion can fall in the same cycle as a flag clear or a fresh trigger. A clear must then lose to the set, and the trigger must be ignored because the block is still busy. The bench provokes both by holding `done_clr` or `sw_start` high across the whole final step. The exact cycle is not targeted. A behavioural model, stepped on every edge, decides what `done`, `busy` and `trial_code` must be afterwards. A mid-conversion flip of `cfg_left_adj` is checked the same way to show that the stored word never changes before the final edge.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int SAR_RES_W = 10;
  localparam int SAR_REG_W = 16;
  localparam int SAR_DIV_W = 8;

  typedef enum logic {
    TRIG_SOFT  = 1'b0,
    TRIG_TIMER = 1'b1
  } trig_src_e;
endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= div;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= div;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic             cmp,
  input  logic             dac_load,
  input  logic [RES_W-1:0] dac_data,
  output logic [RES_W-1:0] code,
  output logic             busy,
  output logic             fin,
  output logic [RES_W-1:0] final_code
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] MID = {1'b1, {(RES_W-1){1'b0}}};

  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] decided;
  logic [RES_W-1:0] nxt;

  always_comb begin
    decided = code;
    if (!cmp) decided[idx_q] = 1'b0;
    nxt = decided;
    if (idx_q != '0) nxt[idx_q - IDX_W'(1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= '0;
      idx_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      code  <= MID;
      idx_q <= IDX_W'(RES_W-1);
      busy  <= 1'b1;
    end else if (dac_load) begin
      code  <= dac_data;
    end else if (tick) begin
      code <= nxt;
      if (idx_q == '0) busy  <= 1'b0;
      else             idx_q <= idx_q - IDX_W'(1);
    end
  end

  assign fin        = tick && (idx_q == '0);
  assign final_code = decided;

  assert_first_trial_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> code == MID);

  assert_dac_load_R10: assert property (@(posedge clk) disable iff (rst)
    dac_load |=> code == $past(dac_data));
endmodule

// File: rtl/sar_fmt.sv
module sar_fmt #(
  parameter int RES_W = 10,
  parameter int REG_W = 16
) (
  input  logic [RES_W-1:0] code,
  input  logic             left,
  output logic [REG_W-1:0] word
);
  localparam int PAD_W = REG_W - RES_W;

  logic [RES_W-1:0] sgn;

  assign sgn = {~code[RES_W-1], code[RES_W-2:0]};

  always_comb begin
    if (left) word = {sgn, {PAD_W{1'b0}}};
    else      word = {{PAD_W{sgn[RES_W-1]}}, sgn};
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W = SAR_RES_W,
  parameter int REG_W = SAR_REG_W,
  parameter int DIV_W = SAR_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_dac_mode,
  input  logic             cfg_left_adj,
  input  logic             cfg_trig_sel,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             sw_start,
  input  logic             tmr_trig,
  input  logic             dac_wr_en,
  input  logic [RES_W-1:0] dac_wr_data,
  input  logic             cmp_in,
  input  logic             done_clr,
  input  logic             rd_hi,
  output logic [RES_W-1:0] trial_code,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic [REG_W-1:0] result
);
  trig_src_e        src;
  logic             trig_hit;
  logic             start_ok;
  logic             dac_ok;
  logic             tick;
  logic             fin;
  logic [RES_W-1:0] final_code;
  logic [REG_W-1:0] fmt_word;

  assign src      = trig_src_e'(cfg_trig_sel);
  assign trig_hit = (src == TRIG_TIMER) ? tmr_trig : sw_start;
  assign start_ok = trig_hit && !cfg_dac_mode && !busy;
  assign dac_ok   = dac_wr_en && cfg_dac_mode && !busy;

  sar_step_timer #(.DIV_W(DIV_W)) timer_i (
    .clk (clk),
    .rst (rst),
    .load(start_ok),
    .run (busy),
    .div (cfg_div),
    .tick(tick)
  );

  sar_search #(.RES_W(RES_W)) search_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start_ok),
    .tick      (tick),
    .cmp       (cmp_in),
    .dac_load  (dac_ok),
    .dac_data  (dac_wr_data),
    .code      (trial_code),
    .busy      (busy),
    .fin       (fin),
    .final_code(final_code)
  );

  sar_fmt #(.RES_W(RES_W), .REG_W(REG_W)) fmt_i (
    .code(final_code),
    .left(cfg_left_adj),
    .word(fmt_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      if (fin)                       done <= 1'b1;
      else if (done_clr || rd_hi)    done <= 1'b0;
      if (fin) result <= fmt_word;
    end
  end

  assign irq = done;

  assert_end_sets_done_R3: assert property (@(posedge clk) disable iff (rst)
    fin |=> done && !busy);

  assert_clear_done_R8: assert property (@(posedge clk) disable iff (rst)
    (done_clr || rd_hi) && !fin |=> !done);

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(fin) |-> $stable(result));
endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
  localparam int RW = 10;
  localparam int GW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_dac_mode, cfg_left_adj, cfg_trig_sel;
  logic [DW-1:0] cfg_div;
  logic          sw_start, tmr_trig, dac_wr_en;
  logic [RW-1:0] dac_wr_data;
  logic          cmp_in, done_clr, rd_hi;
  logic [RW-1:0] trial_code;
  logic          busy, done, irq;
  logic [GW-1:0] result;

  int vin;
  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  int m_busy, m_code, m_cnt, m_bit, m_done, m_result;

  always #5 clk = ~clk;

  assign cmp_in = (int'(trial_code) <= vin);

  sar_conv_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_dac_mode(cfg_dac_mode), .cfg_left_adj(cfg_left_adj),
    .cfg_trig_sel(cfg_trig_sel), .cfg_div(cfg_div), .sw_start(sw_start),
    .tmr_trig(tmr_trig), .dac_wr_en(dac_wr_en), .dac_wr_data(dac_wr_data),
    .cmp_in(cmp_in), .done_clr(done_clr), .rd_hi(rd_hi), .trial_code(trial_code),
    .busy(busy), .done(done), .irq(irq), .result(result)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, stepped on every rising edge
  always @(posedge clk) begin
    int trig, s, fin;
    fin = 0;
    if (rst) begin
      m_busy = 0; m_code = 0; m_cnt = 0; m_bit = 0; m_done = 0; m_result = 0;
    end else begin
      if (m_busy != 0) begin
        if (m_cnt != 0) m_cnt--;
        else begin
          if (!(m_code <= vin)) m_code &= ~(1 << m_bit);
          if (m_bit == 0) begin
            m_busy = 0; fin = 1;
            s = m_code ^ 512;
            if (cfg_left_adj) m_result = (s << 6) & 16'hFFFF;
            else              m_result = (s >= 512) ? (s | 16'hFC00) : s;
          end else begin
            m_bit--;
            m_code |= (1 << m_bit);
            m_cnt = int'(cfg_div);
          end
        end
      end else begin
        trig = cfg_trig_sel ? int'(tmr_trig) : int'(sw_start);
        if (trig != 0 && !cfg_dac_mode) begin
          m_busy = 1; m_code = 512; m_bit = 9; m_cnt = int'(cfg_div);
        end else if (dac_wr_en && cfg_dac_mode) begin
          m_code = int'(dac_wr_data);
        end
      end
      if (fin != 0) m_done = 1;
      else if (done_clr || rd_hi) m_done = 0;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R2 R10 trial_code", int'(trial_code), m_code);
      chk("R1 R3 R7 busy", int'(busy), m_busy);
      chk("R3 R8 done", int'(done), m_done);
      chk("R9 irq", int'(irq), m_done);
      chk("R4 R5 R6 R11 result", int'(result), m_result);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sw();
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk) tmr_trig = 1'b1;
    @(negedge clk) tmr_trig = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    rst = 1'b1; cfg_dac_mode = 1'b0; cfg_left_adj = 1'b0; cfg_trig_sel = 1'b0;
    cfg_div = 8'd2; sw_start = 1'b0; tmr_trig = 1'b0; dac_wr_en = 1'b0;
    dac_wr_data = '0; done_clr = 1'b0; rd_hi = 1'b0; vin = 700;
    step(3);
    // R12: reset values
    chk("R12 busy", int'(busy), 0);
    chk("R12 done", int'(done), 0);
    chk("R12 irq", int'(irq), 0);
    chk("R12 trial_code", int'(trial_code), 0);
    chk("R12 result", int'(result), 0);
    rst = 1'b0; cmp_on = 1'b1;

    // R1 R2 R4 R5: right-aligned positive result, software start
    pulse_sw();
    step(40);
    @(negedge clk) rd_hi = 1'b1;
    @(negedge clk) rd_hi = 1'b0;

    // R6: left-aligned, full-scale negative, fastest step
    cfg_left_adj = 1'b1; cfg_div = 8'd0; vin = 0;
    pulse_sw();
    step(15);
    @(negedge clk) done_clr = 1'b1;
    @(negedge clk) done_clr = 1'b0;

    // R7: timer selected, software pulse ignored; retrigger while busy ignored
    cfg_trig_sel = 1'b1; cfg_div = 8'd5; vin = 1023;
    pulse_sw();
    step(3);
    pulse_tmr();
    step(5);
    pulse_tmr();
    // R11: alignment change mid-conversion must not touch result
    cfg_left_adj = 1'b0;
    step(70);

    // R8: clear held across the end of conversion, set wins
    cfg_trig_sel = 1'b0; cfg_div = 8'd1; vin = 512;
    pulse_sw();
    done_clr = 1'b1;
    step(25);
    done_clr = 1'b0;

    // R7: start held across the end; ignored while busy, restarts after
    vin = 511; cfg_left_adj = 1'b1;
    @(negedge clk) sw_start = 1'b1;
    step(24);
    sw_start = 1'b0;
    step(25);
    @(negedge clk) rd_hi = 1'b1;
    @(negedge clk) rd_hi = 1'b0;

    // R10: output mode loads code, start ignored
    cfg_dac_mode = 1'b1;
    @(negedge clk) begin dac_wr_en = 1'b1; dac_wr_data = 10'h155; end
    @(negedge clk) dac_wr_en = 1'b0;
    pulse_sw();
    step(4);
    @(negedge clk) begin dac_wr_en = 1'b1; dac_wr_data = 10'h3FF; end
    @(negedge clk) dac_wr_en = 1'b0;
    step(3);

    // R3 R5: back to conversion, negative right-aligned value
    cfg_dac_mode = 1'b0; cfg_left_adj = 1'b0; cfg_div = 8'd3; vin = 100;
    pulse_sw();
    step(50);
    summary();
  end
endmodule